// File: doc/BRIEF.md
# SDRAM Command Decoder and Legality Checker

This block watches the command pins of a four-bank synchronous DRAM on every rising clock edge. It turns each sampled cycle into one command code. The codes cover mode register load, refresh, self-refresh entry and exit, bank activate, read, write, single-bank and all-bank precharge, burst stop, power-down (or clock-suspend) entry and exit, no operation, deselect, and a hold code used while CKE stays low. Every output is registered, so each one shows the result of the edge just taken.

From the commands it accepts, the block keeps its own copy of the device state:
- which banks are open,
- the programmed burst length,
- a burst-beat counter for each bank, including any pending auto precharge,
- the mode-register recovery window,
- the self-refresh and power-down states.

A command that breaks a rule gives a one-cycle illegal pulse, sets a sticky error flag and records the offending code. The illegal command itself changes none of the tracked state.

It also produces two data-mask strobes, one for writes and one for reads. The write strobe is asserted for a masked write beat after the edge where DQM was sampled. The read high-impedance strobe is asserted two edges later than that.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With CKE high on the previous and current edge, {cs_n,ras_n,cas_n,we_n} decodes as follows:
  - 1xxx gives deselect (code 1).
  - 0000 gives mode load (2).
  - 0001 gives refresh (3).
  - 0011 gives activate (6).
  - 0101 gives read (7).
  - 0100 gives write (8).
  - 0010 gives precharge: a10 low gives code 9 and a10 high gives code 10.
  - 0110 gives burst stop (11).
  - 0111 gives no operation (0).
  - cmd_out shows the code after the edge.
- R2: CKE is taken together with its value at the previous edge:
  - Previous high, now low, with a refresh encoding: self-refresh entry (4).
  - Previous high, now low, any other encoding: power-down entry (12).
  - Previous low, now high: exit, code 5 if in self-refresh and code 13 otherwise.
  - Low on both edges: hold (14).
  - in_sref and in_pdown follow the accepted entries and exits.
- R3: ba selects the bank, and bank_open bit ba is that bank. An accepted activate opens the bank. An activate to a bank that is already open is illegal.
- R4: A precharge with a10 low closes only bank ba. A precharge with a10 high closes every bank and ignores ba.
- R5: A read or write to a closed bank is illegal. An accepted read or write loads that bank's counter with the burst length BL. burst_busy stays high until the edge BL edges after the command.
- R6: A read or write with a10 high closes its bank at the edge BL edges after the command. From the command edge through that closing edge, any read or write is illegal.
- R7: A mode load is legal only with all banks closed. It sets burst_len from mode_bl: 0 gives 1, 1 gives 2, 2 gives 4, and any other value gives 8. After reset burst_len is 1.
- R8: For the two edges after an accepted mode load, any code other than no operation, deselect or hold is illegal. The third edge is free.
- R9: Refresh and self-refresh entry are legal only with all banks closed. While in self-refresh, every bank is closed.
- R10: Burst stop ends the current burst (burst_busy falls) and leaves the bank open.
- R11: wr_mask is high after an edge where dqm is high and a write beat occurs. A write beat is the write command edge or one of the following BL-1 edges. There is no added latency.
- R12: rd_hiz after edge n equals the dqm value sampled at edge n-2, whatever command is on the bus.
- R13: An illegal command does three things: it pulses cmd_illegal for one cycle, sets err_sticky until reset, and loads err_cmd with its code. It changes no bank, burst, mode or power state.
- R14: While rst_n is low, all of these are zero: banks, burst, errors, strobes and power states. burst_len is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Auto-precharge / all-bank flag |
| mode_bl | input | 3 | Burst-length field on the address bus at mode load |
| dqm | input | 1 | Data mask pin |
| cmd_out | output | 4 | Decoded command code |
| bank_open | output | 4 | Open flag per bank |
| burst_busy | output | 1 | A burst counter is running |
| burst_len | output | 4 | Programmed burst length |
| in_sref | output | 1 | In self-refresh |
| in_pdown | output | 1 | In power-down or clock suspend |
| cmd_illegal | output | 1 | Illegal command pulse |
| err_sticky | output | 1 | Sticky error flag |
| err_cmd | output | 4 | Code of the latest illegal command |
| wr_mask | output | 1 | Write beat masked |
| rd_hiz | output | 1 | Read output forced high impedance |

## Verification
The bench probes the exact edge where each window closes.
- Mode recovery: an activate on the second edge after a mode load must be refused, and one on the third must be accepted. A counter that is off by one frees the bus early or blocks it late.
- Auto-precharge lockout: a read on the very edge where auto precharge closes the bank must be refused. The next edge must find the bank closed. A design that ends the burst one beat early would accept that read.
- Mask strobes: the write strobe is checked on the command edge and on the edge after the last beat. The read strobe is checked two edges after a DQM pattern, which catches a shared or mis-sized pipeline.
- Refused commands: a refused mode load must leave the burst length unchanged. A refused self-refresh entry must leave in_sref low, so that the later CKE rise decodes as a power-down exit.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_DESEL    = 4'd1,
    CMD_MRS      = 4'd2,
    CMD_REF      = 4'd3,
    CMD_SREF_IN  = 4'd4,
    CMD_SREF_OUT = 4'd5,
    CMD_ACT      = 4'd6,
    CMD_RD       = 4'd7,
    CMD_WR       = 4'd8,
    CMD_PRE      = 4'd9,
    CMD_PREALL   = 4'd10,
    CMD_BST      = 4'd11,
    CMD_PD_IN    = 4'd12,
    CMD_PD_OUT   = 4'd13,
    CMD_HOLD     = 4'd14
  } cmd_e;

  localparam int LEN_W  = 4;
  localparam int MODE_W = 3;

  // Burst length field at mode load: 0->1, 1->2, 2->4, others->8
  function automatic logic [LEN_W-1:0] len_from_field(input logic [MODE_W-1:0] f);
    case (f)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic is_quiet(input cmd_e c);
    return (c == CMD_NOP) || (c == CMD_DESEL) || (c == CMD_HOLD);
  endfunction

  function automatic logic is_column(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

  function automatic logic needs_idle(input cmd_e c);
    return (c == CMD_MRS) || (c == CMD_REF) || (c == CMD_SREF_IN);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  input  logic in_sref,
  output cmd_e cmd
);

  cmd_e base;

  always_comb begin
    if (cs_n) begin
      base = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  base = CMD_MRS;
        3'b001:  base = CMD_REF;
        3'b010:  base = a10 ? CMD_PREALL : CMD_PRE;
        3'b011:  base = CMD_ACT;
        3'b100:  base = CMD_WR;
        3'b101:  base = CMD_RD;
        3'b110:  base = CMD_BST;
        default: base = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    case ({cke_prev, cke})
      2'b11:   cmd = base;
      2'b10:   cmd = (base == CMD_REF) ? CMD_SREF_IN : CMD_PD_IN;
      2'b01:   cmd = in_sref ? CMD_SREF_OUT : CMD_PD_OUT;
      default: cmd = CMD_HOLD;
    endcase
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_open,
  input  logic             do_close,
  input  logic             do_burst,
  input  logic             kill,
  input  logic             ap_req,
  input  logic [CNT_W-1:0] len,
  output logic             is_open,
  output logic [CNT_W-1:0] remaining,
  output logic             ap_pending,
  output logic             ap_close
);

  logic last_beat;
  assign last_beat = (remaining == CNT_W'(1));
  assign ap_close  = ap_pending && last_beat && !do_close && !do_burst && !kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open    <= 1'b0;
      remaining  <= '0;
      ap_pending <= 1'b0;
    end else if (do_close) begin
      is_open    <= 1'b0;
      remaining  <= '0;
      ap_pending <= 1'b0;
    end else begin
      if (do_open) begin
        is_open <= 1'b1;
      end
      if (do_burst) begin
        remaining  <= len;
        ap_pending <= ap_req;
      end else if (kill) begin
        remaining  <= '0;
        ap_pending <= 1'b0;
      end else if (remaining != '0) begin
        remaining <= remaining - CNT_W'(1);
        if (ap_close) begin
          is_open    <= 1'b0;
          ap_pending <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  cmd_e            cmd,
  input  logic [BA_W-1:0] ba,
  input  logic [NB-1:0]   open_map,
  input  logic            ap_lock,
  input  logic            mrs_busy,
  output logic            illegal
);

  logic sel_open;
  logic any_open;
  assign sel_open = open_map[ba];
  assign any_open = |open_map;

  always_comb begin
    illegal = 1'b0;
    if (mrs_busy && !is_quiet(cmd)) begin
      illegal = 1'b1;
    end
    if (needs_idle(cmd) && any_open) begin
      illegal = 1'b1;
    end
    if ((cmd == CMD_ACT) && sel_open) begin
      illegal = 1'b1;
    end
    if (is_column(cmd) && (!sel_open || ap_lock)) begin
      illegal = 1'b1;
    end
  end

endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
  parameter int LAT = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [LAT:0] stage;

  generate
    if (LAT == 0) begin : g_direct
      always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[LAT-1:0], din};
      end
    end
  endgenerate

  assign dout = stage[LAT];

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BANKS       = 4,
  parameter int T_MRD       = 2,
  parameter int RD_MASK_LAT = 2,
  parameter int WR_MASK_LAT = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [$clog2(BANKS)-1:0]   ba,
  input  logic                       a10,
  input  logic [2:0]                 mode_bl,
  input  logic                       dqm,
  output logic [3:0]                 cmd_out,
  output logic [BANKS-1:0]           bank_open,
  output logic                       burst_busy,
  output logic [3:0]                 burst_len,
  output logic                       in_sref,
  output logic                       in_pdown,
  output logic                       cmd_illegal,
  output logic                       err_sticky,
  output logic [3:0]                 err_cmd,
  output logic                       wr_mask,
  output logic                       rd_hiz
);

  localparam int BA_W  = $clog2(BANKS);
  localparam int CNT_W = LEN_W;
  localparam int MRD_W = $clog2(T_MRD + 1);

  // registered state
  logic             cke_q;
  logic             sref_q;
  logic             pd_q;
  logic [CNT_W-1:0] bl_q;
  logic [MRD_W-1:0] mrs_cnt;
  logic             burst_wr_q;
  cmd_e             cmd_q;
  logic             illegal_q;
  logic             sticky_q;
  cmd_e             err_cmd_q;

  // decoded command and verdict
  cmd_e cmd_now;
  logic illegal_now;
  logic accept;
  logic mrs_busy;
  logic ap_lock;

  // named events
  logic ev_mrs, ev_act, ev_rw, ev_wr, ev_pre_one, ev_pre_all, ev_bst;
  logic ev_sref_in, ev_sref_out, ev_pd_in, ev_pd_out;
  logic ev_ap_close;
  logic wr_beat;

  // per-bank views
  logic [BANKS-1:0] open_v;
  logic [BANKS-1:0] ap_pend_v;
  logic [BANKS-1:0] ap_close_v;
  logic [BANKS-1:0] multi_v;
  logic [BANKS-1:0] busy_v;

  sdram_cmd_decode u_dec (
    .cke_prev (cke_q),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (a10),
    .in_sref  (sref_q),
    .cmd      (cmd_now)
  );

  assign mrs_busy = (mrs_cnt != '0);
  assign ap_lock  = |ap_pend_v;

  sdram_rule_check #(.NB(BANKS), .BA_W(BA_W)) u_rules (
    .cmd      (cmd_now),
    .ba       (ba),
    .open_map (open_v),
    .ap_lock  (ap_lock),
    .mrs_busy (mrs_busy),
    .illegal  (illegal_now)
  );

  assign accept      = !illegal_now;
  assign ev_mrs      = accept && (cmd_now == CMD_MRS);
  assign ev_act      = accept && (cmd_now == CMD_ACT);
  assign ev_rw       = accept && is_column(cmd_now);
  assign ev_wr       = accept && (cmd_now == CMD_WR);
  assign ev_pre_one  = accept && (cmd_now == CMD_PRE);
  assign ev_pre_all  = accept && (cmd_now == CMD_PREALL);
  assign ev_bst      = accept && (cmd_now == CMD_BST);
  assign ev_sref_in  = accept && (cmd_now == CMD_SREF_IN);
  assign ev_sref_out = accept && (cmd_now == CMD_SREF_OUT);
  assign ev_pd_in    = accept && (cmd_now == CMD_PD_IN);
  assign ev_pd_out   = accept && (cmd_now == CMD_PD_OUT);

  generate
    for (genvar i = 0; i < BANKS; i++) begin : g_bank
      logic             hit;
      logic [CNT_W-1:0] rem;
      assign hit = (ba == BA_W'(i));

      sdram_bank_track #(.CNT_W(CNT_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_open    (ev_act && hit),
        .do_close   (ev_pre_all || (ev_pre_one && hit)),
        .do_burst   (ev_rw && hit),
        .kill       (ev_bst || (ev_rw && !hit)),
        .ap_req     (a10),
        .len        (bl_q),
        .is_open    (open_v[i]),
        .remaining  (rem),
        .ap_pending (ap_pend_v[i]),
        .ap_close   (ap_close_v[i])
      );

      assign multi_v[i] = (rem > CNT_W'(1));
      assign busy_v[i]  = (rem != '0);
    end
  endgenerate

  assign ev_ap_close = |ap_close_v;

  // a write beat: the command edge itself, or a later edge with beats left
  assign wr_beat = ev_wr ||
                   (burst_wr_q && (|multi_v) && !ev_bst && !ev_rw &&
                    !ev_pre_all && !ev_pre_one);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q      <= 1'b1;
      sref_q     <= 1'b0;
      pd_q       <= 1'b0;
      bl_q       <= CNT_W'(1);
      mrs_cnt    <= '0;
      burst_wr_q <= 1'b0;
      cmd_q      <= CMD_NOP;
      illegal_q  <= 1'b0;
      sticky_q   <= 1'b0;
      err_cmd_q  <= CMD_NOP;
    end else begin
      cke_q     <= cke;
      cmd_q     <= cmd_now;
      illegal_q <= illegal_now;
      if (illegal_now) begin
        sticky_q  <= 1'b1;
        err_cmd_q <= cmd_now;
      end
      if (ev_mrs) begin
        bl_q    <= len_from_field(mode_bl);
        mrs_cnt <= MRD_W'(T_MRD);
      end else if (mrs_busy) begin
        mrs_cnt <= mrs_cnt - MRD_W'(1);
      end
      if (ev_rw) begin
        burst_wr_q <= ev_wr;
      end
      if (ev_sref_in) begin
        sref_q <= 1'b1;
      end else if (ev_sref_out) begin
        sref_q <= 1'b0;
      end
      if (ev_pd_in) begin
        pd_q <= 1'b1;
      end else if (ev_pd_out) begin
        pd_q <= 1'b0;
      end
    end
  end

  sdram_dqm_pipe #(.LAT(WR_MASK_LAT)) u_wr_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (dqm && wr_beat),
    .dout  (wr_mask)
  );

  sdram_dqm_pipe #(.LAT(RD_MASK_LAT)) u_rd_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (dqm),
    .dout  (rd_hiz)
  );

  assign cmd_out     = cmd_q;
  assign bank_open   = open_v;
  assign burst_busy  = |busy_v;
  assign burst_len   = bl_q;
  assign in_sref     = sref_q;
  assign in_pdown    = pd_q;
  assign cmd_illegal = illegal_q;
  assign err_sticky  = sticky_q;
  assign err_cmd     = err_cmd_q;

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdram_mon_pkg::*;
#(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dqm,
  input logic [3:0]    cmd_out,
  input logic [NB-1:0] bank_open,
  input logic          burst_busy,
  input logic [3:0]    burst_len,
  input logic          in_sref,
  input logic          cmd_illegal,
  input logic          err_sticky,
  input logic          rd_hiz,
  input logic          ev_ap_close
);

  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)              cyc <= 2'd0;
    else if (cyc != 2'd3)    cyc <= cyc + 2'd1;
  end

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_sticky)); // R13

  AST_PULSE_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_illegal |-> err_sticky); // R13

  AST_MRD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == CMD_MRS && !cmd_illegal) |=>
      (cmd_out == CMD_NOP || cmd_out == CMD_DESEL || cmd_out == CMD_HOLD || cmd_illegal)); // R8

  AST_MRS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && cmd_out == CMD_MRS && !cmd_illegal) |-> ($past(bank_open) == '0)); // R7

  AST_REF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && (cmd_out == CMD_REF || cmd_out == CMD_SREF_IN) && !cmd_illegal)
      |-> ($past(bank_open) == '0)); // R9

  AST_SREF_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    in_sref |-> (bank_open == '0)); // R9

  AST_RD_HIZ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (rd_hiz == $past(dqm, 3))); // R12

  AST_AP_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ap_close |=> !burst_busy); // R6

  AST_LEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(burst_len) && (burst_len <= 4'd8)); // R7

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NB(BANKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dqm         (dqm),
  .cmd_out     (cmd_out),
  .bank_open   (bank_open),
  .burst_busy  (burst_busy),
  .burst_len   (burst_len),
  .in_sref     (in_sref),
  .cmd_illegal (cmd_illegal),
  .err_sticky  (err_sticky),
  .rd_hiz      (rd_hiz),
  .ev_ap_close (ev_ap_close)
);

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic       a10 = 1'b0;
  logic [2:0] mode_bl = 3'd0;
  logic       dqm = 1'b0;
  logic [3:0] cmd_out;
  logic [3:0] bank_open;
  logic       burst_busy;
  logic [3:0] burst_len;
  logic       in_sref, in_pdown, cmd_illegal, err_sticky;
  logic [3:0] err_cmd;
  logic       wr_mask, rd_hiz;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sdram_cmd_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .mode_bl(mode_bl),
    .dqm(dqm), .cmd_out(cmd_out), .bank_open(bank_open),
    .burst_busy(burst_busy), .burst_len(burst_len), .in_sref(in_sref),
    .in_pdown(in_pdown), .cmd_illegal(cmd_illegal), .err_sticky(err_sticky),
    .err_cmd(err_cmd), .wr_mask(wr_mask), .rd_hiz(rd_hiz)
  );

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] P_NOP = 4'b0111, P_MRS = 4'b0000, P_REF = 4'b0001,
                         P_ACT = 4'b0011, P_RD  = 4'b0101, P_WR  = 4'b0100,
                         P_PRE = 4'b0010, P_BST = 4'b0110, P_DES = 4'b1111;

  // {cke, pins[3:0], ba[1:0], a10, dqm, mode[2:0], exp_cmd[3:0], exp_illegal}
  localparam int NV = 18;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0, 4'd0,  1'b0},
    {1'b1, P_MRS, 2'd0, 1'b0, 1'b0, 3'd2, 4'd2,  1'b0},  // BL 4
    {1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0, 4'd0,  1'b0},
    {1'b1, P_ACT, 2'd1, 1'b0, 1'b0, 3'd0, 4'd6,  1'b1},  // R8 second edge
    {1'b1, P_ACT, 2'd1, 1'b0, 1'b0, 3'd0, 4'd6,  1'b0},  // R8 third edge
    {1'b1, P_ACT, 2'd1, 1'b0, 1'b0, 3'd0, 4'd6,  1'b1},  // R3 already open
    {1'b1, P_RD,  2'd2, 1'b0, 1'b0, 3'd0, 4'd7,  1'b1},  // R5 closed bank
    {1'b1, P_RD,  2'd1, 1'b1, 1'b0, 3'd0, 4'd7,  1'b0},  // R6 auto precharge
    {1'b1, P_WR,  2'd1, 1'b0, 1'b0, 3'd0, 4'd8,  1'b1},  // R6 lockout
    {1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0, 4'd0,  1'b0},
    {1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0, 4'd0,  1'b0},
    {1'b1, P_RD,  2'd1, 1'b0, 1'b0, 3'd0, 4'd7,  1'b1},  // R6 closing edge
    {1'b1, P_REF, 2'd0, 1'b0, 1'b0, 3'd0, 4'd3,  1'b0},  // R9 all closed
    {1'b1, P_ACT, 2'd0, 1'b0, 1'b0, 3'd0, 4'd6,  1'b0},
    {1'b1, P_MRS, 2'd0, 1'b0, 1'b0, 3'd0, 4'd2,  1'b1},  // R7 bank open
    {1'b1, P_PRE, 2'd3, 1'b1, 1'b0, 3'd0, 4'd10, 1'b0},  // R4 all banks
    {1'b1, P_DES, 2'd0, 1'b0, 1'b0, 3'd0, 4'd1,  1'b0},
    {1'b1, P_BST, 2'd0, 1'b0, 1'b0, 3'd0, 4'd11, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic k, input logic [3:0] p, input logic [1:0] b,
                       input logic a, input logic d, input logic [2:0] m);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = p;
    ba = b;
    a10 = a;
    dqm = d;
    mode_bl = m;
  endtask

  task automatic step(input logic k, input logic [3:0] p, input logic [1:0] b,
                      input logic a, input logic d, input logic [2:0] m);
    drive(k, p, b, a, d, m);
    tick();
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    drive(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    repeat (3) tick();
    // R14 reset state
    chk("R14 bank_open", bank_open, 0);
    chk("R14 err_sticky", err_sticky, 0);
    chk("R14 cmd_illegal", cmd_illegal, 0);
    chk("R14 burst_busy", burst_busy, 0);
    chk("R14 burst_len", burst_len, 1);
    chk("R14 in_sref", in_sref, 0);
    chk("R14 in_pdown", in_pdown, 0);
    chk("R14 wr_mask", wr_mask, 0);
    chk("R14 rd_hiz", rd_hiz, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      step(v[16], v[15:12], v[11:10], v[9], v[8], v[7:5]);
      chk($sformatf("R1 cmd vec%0d", i), cmd_out, int'(v[4:1]));
      chk($sformatf("R13 illegal vec%0d", i), cmd_illegal, int'(v[0]));
    end
    chk("R13 sticky", err_sticky, 1);
    chk("R13 err_cmd", err_cmd, 2);
    chk("R13 refused mode load kept length", burst_len, 4);
    chk("R4 all closed", bank_open, 0);

    // write mask, latency 0; read hi-z, latency 2
    step(1'b1, P_ACT, 2'd2, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_WR,  2'd2, 1'b0, 1'b1, 3'd0);
    chk("R11 mask on command edge", wr_mask, 1);
    chk("R5 busy", burst_busy, 1);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R11 unmasked beat", wr_mask, 0);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b1, 3'd0);
    chk("R11 third beat", wr_mask, 1);
    chk("R12 hiz two later", rd_hiz, 1);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b1, 3'd0);
    chk("R11 last beat", wr_mask, 1);
    chk("R12 hiz low", rd_hiz, 0);
    chk("R5 busy last beat", burst_busy, 1);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b1, 3'd0);
    chk("R11 after burst", wr_mask, 0);
    chk("R5 burst over", burst_busy, 0);
    chk("R12 hiz follows", rd_hiz, 1);

    // burst stop
    step(1'b1, P_RD,  2'd2, 1'b0, 1'b0, 3'd0);
    chk("R5 read accepted", cmd_illegal, 0);
    chk("R11 read not masked", wr_mask, 0);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_BST, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R10 burst ended", burst_busy, 0);
    chk("R10 bank stays open", bank_open, 4'b0100);

    // auto precharge close timing
    step(1'b1, P_RD,  2'd2, 1'b1, 1'b0, 3'd0);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R6 open before close edge", bank_open, 4'b0100);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R6 closed at BL edge", bank_open, 0);

    // single and all-bank precharge
    step(1'b1, P_ACT, 2'd3, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_ACT, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R3 two banks open", bank_open, 4'b1001);
    step(1'b1, P_PRE, 2'd3, 1'b0, 1'b0, 3'd0);
    chk("R4 single precharge", bank_open, 4'b0001);
    step(1'b1, P_ACT, 2'd3, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_PRE, 2'd2, 1'b1, 1'b0, 3'd0);
    chk("R4 all-bank ignores ba", bank_open, 0);

    // self refresh
    step(1'b0, P_REF, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R2 sref entry", cmd_out, 4);
    chk("R9 sref legal", cmd_illegal, 0);
    chk("R2 in_sref", in_sref, 1);
    step(1'b0, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R2 hold", cmd_out, 14);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R2 sref exit", cmd_out, 5);
    chk("R2 sref cleared", in_sref, 0);

    // power down and refused self refresh
    step(1'b1, P_ACT, 2'd1, 1'b0, 1'b0, 3'd0);
    step(1'b0, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R2 pd entry", cmd_out, 12);
    chk("R2 in_pdown", in_pdown, 1);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R2 pd exit", cmd_out, 13);
    chk("R2 pd cleared", in_pdown, 0);
    step(1'b0, P_REF, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R9 sref with open bank", cmd_illegal, 1);
    chk("R9 sref not entered", in_sref, 0);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R2 exit decodes as pd exit", cmd_out, 13);

    // burst length field and recovery boundary
    step(1'b1, P_PRE, 2'd0, 1'b1, 1'b0, 3'd0);
    step(1'b1, P_MRS, 2'd0, 1'b0, 1'b0, 3'd1);
    chk("R7 length 2", burst_len, 2);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_MRS, 2'd0, 1'b0, 1'b0, 3'd6);
    chk("R7 length 8 for other field", burst_len, 8);
    step(1'b1, P_DES, 2'd0, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_MRS, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R7 length 1", burst_len, 1);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 3'd0);
    step(1'b1, P_ACT, 2'd0, 1'b0, 1'b0, 3'd0);
    chk("R8 third edge free", cmd_illegal, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule